// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a hardware master for a three-wire serial EEPROM that is addressed in 16-bit words. A single-cycle start request carries a word address. The reader then drives chip select, serial clock and serial data-in to shift out a 9-bit read command. It samples sixteen bits from the memory's data-out line and closes the access. At the end it presents the assembled word together with a one-cycle done pulse.

The access is a fixed series of line states, each called a half-period. The first half-period drives every line low. The second raises the clock with select still low. Eighteen half-periods follow, carrying the command bits as a low-clock and high-clock pair per bit, with select high. One half-period holds select high with the clock low before the data phase. Thirty-two half-periods make up the sixteen data bit pairs. Two half-periods end the access: every line low, then a clock raise with select low. Every half-period lasts `HALF_DIV` system clocks. The access therefore takes 55 × `HALF_DIV` cycles with the default sizes.

Top module: `eeprom_word_reader`

## Requirements
- R1: While reset is held, and whenever the reader is idle, `busy_o`, `done_o`, `ee_cs_o`, `ee_sk_o` and `ee_di_o` are low. After reset `data_o` is zero.
- R2: A start seen while idle sets `busy_o` from the next cycle. `busy_o` stays high for exactly 55 × `HALF_DIV` cycles. It falls in the same cycle that `done_o` rises.
- R3: The first half-period drives cs=0, sk=0, di=0. The second drives cs=0, sk=1, di=0.
- R4: The command is {3'b110, addr[5:0]}, sent bit 8 first. Each bit takes two half-periods with cs=1 and di equal to the bit: first with sk=0, then with sk=1.
- R5: After the command, one half-period drives cs=1, sk=0, di=0.
- R6: Sixteen data bits follow. Each bit takes a half-period with cs=1, sk=0, then a half-period with cs=1, sk=1. `ee_do_i` is sampled on the last system clock of the sk=1 half. The first bit sampled becomes bit 15 of the result.
- R7: The access ends with one half-period of cs=0, sk=0, di=0, then one half-period of cs=0, sk=1, di=0.
- R8: `done_o` lasts one cycle. `data_o` changes only in the cycle where `done_o` is high, and holds its value until the next completion.
- R9: A start while busy is ignored. The address, the line sequence and the timing of the access already under way are unchanged.
- R10: Each line state is held for exactly `HALF_DIV` system clocks.
- R11: `ee_di_o` is never high while `ee_cs_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a read; taken only when idle |
| addr_i | input | ADDR_W | Word address, sampled with an accepted start |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | DATA_W | Word read by the last completed access |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |

## Verification
The line outputs change in the first cycle after the edge that accepts a start. From then on they move to a new state every `HALF_DIV` cycles. The bench builds the expected line state and busy level for each cycle in a queue, and compares one queue entry at every falling clock edge. `done_o` and the new `data_o` are due one cycle after the last queued entry, and `done_o` must fall in the cycle after that. The bench checks both at those points. To expose a sample taken in the wrong half, the emulated memory drives the inverse of each data bit during the clock-low half and the true bit only during the clock-high half.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } ee_lines_t;

  // Step index where the command bits begin
  function automatic int unsigned cmd_first(input int unsigned cmd_w);
    cmd_first = 2;
    if (cmd_w == 0) cmd_first = 2;
  endfunction

  function automatic int unsigned gap_step(input int unsigned cmd_w);
    gap_step = cmd_first(cmd_w) + 2 * cmd_w;
  endfunction

  function automatic int unsigned data_first(input int unsigned cmd_w);
    data_first = gap_step(cmd_w) + 1;
  endfunction

  function automatic int unsigned term_first(input int unsigned cmd_w, input int unsigned data_w);
    term_first = data_first(cmd_w) + 2 * data_w;
  endfunction

  function automatic int unsigned total_steps(input int unsigned cmd_w, input int unsigned data_w);
    total_steps = term_first(cmd_w, data_w) + 2;
  endfunction

  // Line state for a given step of the access
  function automatic ee_lines_t step_lines(input int unsigned step, input logic [31:0] cmd,
                                           input int unsigned cmd_w, input int unsigned data_w);
    ee_lines_t    l;
    int unsigned  idx;
    int unsigned  bitpos;
    l = '0;
    if (step == 1) begin
      l.sk = 1'b1;
    end else if (step >= cmd_first(cmd_w) && step < gap_step(cmd_w)) begin
      idx    = step - cmd_first(cmd_w);
      bitpos = cmd_w - 1 - (idx >> 1);
      l.cs   = 1'b1;
      l.sk   = idx[0];
      l.di   = cmd[bitpos[4:0]];
    end else if (step == gap_step(cmd_w)) begin
      l.cs = 1'b1;
    end else if (step >= data_first(cmd_w) && step < term_first(cmd_w, data_w)) begin
      idx  = step - data_first(cmd_w);
      l.cs = 1'b1;
      l.sk = idx[0];
    end else if (step == term_first(cmd_w, data_w) + 1) begin
      l.sk = 1'b1;
    end
    step_lines = l;
  endfunction

  // True in the clock-high half of a data bit
  function automatic logic is_sample_step(input int unsigned step, input int unsigned cmd_w,
                                          input int unsigned data_w);
    int unsigned idx;
    is_sample_step = 1'b0;
    if (step >= data_first(cmd_w) && step < term_first(cmd_w, data_w)) begin
      idx = step - data_first(cmd_w);
      is_sample_step = idx[0];
    end
  endfunction

endpackage

// File: rtl/eeprom_half_timer.sv
module eeprom_half_timer #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/eeprom_step_seq.sv
module eeprom_step_seq #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CMD_W  = 9,
  parameter int unsigned NSTEPS = 55,
  parameter logic [2:0]  RD_OPC = 3'b110
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      tick_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      last_o,
  output logic [$clog2(NSTEPS)-1:0] step_o,
  output logic [CMD_W-1:0]          cmd_o
);
  localparam int unsigned STEP_W = $clog2(NSTEPS);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NSTEPS - 1);

  logic accept;

  assign accept = start_i && !busy_o;
  assign last_o = busy_o && tick_i && (step_o == STEP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      step_o <= '0;
      cmd_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        busy_o <= 1'b1;
        step_o <= '0;
        cmd_o  <= {RD_OPC, addr_i};
      end else if (last_o) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        step_o <= '0;
      end else if (busy_o && tick_i) begin
        step_o <= step_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eeprom_line_drive.sv
module eeprom_line_drive #(
  parameter int unsigned CMD_W  = 9,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STEP_W = 6
) (
  input  logic              busy_i,
  input  logic              tick_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              sample_o
);
  import eeprom_rd_pkg::*;

  ee_lines_t lines;

  always_comb begin
    lines = '0;
    if (busy_i) lines = step_lines(32'(step_i), 32'(cmd_i), CMD_W, DATA_W);
  end

  assign cs_o     = lines.cs;
  assign sk_o     = lines.sk;
  assign di_o     = lines.di;
  assign sample_o = busy_i && tick_i && is_sample_step(32'(step_i), CMD_W, DATA_W);
endmodule

// File: rtl/eeprom_word_shift.sv
module eeprom_word_shift #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              load_i,
  input  logic              do_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      word_o  <= '0;
    end else begin
      if (sample_i) shreg_q <= {shreg_q[DATA_W-2:0], do_i};
      if (load_i)   word_o  <= shreg_q;
    end
  end
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned HALF_DIV = 2,
  parameter logic [2:0]  RD_OPC   = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i
);
  import eeprom_rd_pkg::*;

  localparam int unsigned CMD_W  = 3 + ADDR_W;
  localparam int unsigned NSTEPS = total_steps(CMD_W, DATA_W);
  localparam int unsigned STEP_W = $clog2(NSTEPS);

  // Internal events, brought out by name for the checker
  logic              tick_w;
  logic              last_w;
  logic              sample_w;
  logic [STEP_W-1:0] step_w;
  logic [CMD_W-1:0]  cmd_w;

  eeprom_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy_o),
    .tick_o (tick_w)
  );

  eeprom_step_seq #(
    .ADDR_W (ADDR_W),
    .CMD_W  (CMD_W),
    .NSTEPS (NSTEPS),
    .RD_OPC (RD_OPC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .addr_i  (addr_i),
    .tick_i  (tick_w),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .last_o  (last_w),
    .step_o  (step_w),
    .cmd_o   (cmd_w)
  );

  eeprom_line_drive #(
    .CMD_W  (CMD_W),
    .DATA_W (DATA_W),
    .STEP_W (STEP_W)
  ) u_lines (
    .busy_i   (busy_o),
    .tick_i   (tick_w),
    .step_i   (step_w),
    .cmd_i    (cmd_w),
    .cs_o     (ee_cs_o),
    .sk_o     (ee_sk_o),
    .di_o     (ee_di_o),
    .sample_o (sample_w)
  );

  eeprom_word_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample_w),
    .load_i   (last_w),
    .do_i     (ee_do_i),
    .word_o   (data_o)
  );
endmodule

// File: rtl/eeprom_word_reader_chk.sv
module eeprom_word_reader_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] data_o,
  input logic              ee_cs_o,
  input logic              ee_sk_o,
  input logic              ee_di_o,
  input logic              tick_w,
  input logic              last_w,
  input logic              sample_w
);
  p_idle_lines_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ee_cs_o && !ee_sk_o && !ee_di_o));

  p_busy_ends_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_done_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_sample_in_high_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_w |-> (ee_cs_o && ee_sk_o));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_data_moves_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_o) |-> done_o);

  p_busy_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_w) |=> busy_o);

  p_hold_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tick_w) |=> $stable({ee_cs_o, ee_sk_o, ee_di_o}));

  p_di_needs_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ee_di_o |-> ee_cs_o);
endmodule

bind eeprom_word_reader eeprom_word_reader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .data_o   (data_o),
  .ee_cs_o  (ee_cs_o),
  .ee_sk_o  (ee_sk_o),
  .ee_di_o  (ee_di_o),
  .tick_w   (tick_w),
  .last_w   (last_w),
  .sample_w (sample_w)
);

// File: tb/eeprom_word_reader_bench.sv
module eeprom_word_reader_bench;
  localparam int H  = 3;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          ee_do_i = 1'b0;
  logic          busy_o, done_o, ee_cs_o, ee_sk_o, ee_di_o;
  logic [DW-1:0] data_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] prev_word = '0;
  logic [2:0] lq[$];
  logic       dq[$];

  always #5 clk = ~clk;

  eeprom_word_reader #(.ADDR_W(AW), .DATA_W(DW), .HALF_DIV(H)) u_eeprom_word_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .data_o(data_o),
    .ee_cs_o(ee_cs_o), .ee_sk_o(ee_sk_o), .ee_di_o(ee_di_o), .ee_do_i(ee_do_i)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One half-period: H cycles of the given lines, with the memory's data-out value
  task automatic push(input logic cs, input logic sk, input logic di, input logic dv);
    repeat (H) begin
      lq.push_back({cs, sk, di});
      dq.push_back(dv);
    end
  endtask

  task automatic build(input logic [AW-1:0] addr, input logic [DW-1:0] word);
    logic [8:0] cmd;
    cmd = {3'b110, addr};
    lq.delete();
    dq.delete();
    push(0, 0, 0, 0);
    push(0, 1, 0, 0);
    for (int i = 8; i >= 0; i--) begin
      push(1, 0, cmd[i], 0);
      push(1, 1, cmd[i], 0);
    end
    push(1, 0, 0, 0);
    for (int j = DW - 1; j >= 0; j--) begin
      push(1, 0, 0, ~word[j]);   // wrong value in the low half
      push(1, 1, 0, word[j]);
    end
    push(0, 0, 0, 0);
    push(0, 1, 0, 0);
  endtask

  function automatic string region(input int k);
    int s;
    s = k / H;
    if (s < 2)  return "R3/R10";
    if (s < 20) return "R4/R10";
    if (s == 20) return "R5/R10";
    if (s < 53) return "R6/R10";
    return "R7/R10";
  endfunction

  task automatic do_read(input logic [AW-1:0] addr, input logic [DW-1:0] word, input int intrude);
    build(addr, word);
    @(negedge clk);
    start_i = 1'b1;
    addr_i  = addr;
    for (int k = 0; k < lq.size(); k++) begin
      @(negedge clk);
      if (k == 0) start_i = 1'b0;
      if (k == intrude) begin start_i = 1'b1; addr_i = ~addr; end   // R9 stimulus
      if (k == intrude + 1) start_i = 1'b0;
      ee_do_i = dq[k];
      check({ee_cs_o, ee_sk_o, ee_di_o} === lq[k], region(k), "lines",
            32'({ee_cs_o, ee_sk_o, ee_di_o}), 32'(lq[k]));
      check(!(ee_di_o && !ee_cs_o), "R11", "di without cs", 32'(ee_di_o), 32'(0));
      check(busy_o === 1'b1 && done_o === 1'b0, "R2", "busy during access",
            32'({busy_o, done_o}), 32'h2);
      check(data_o === prev_word, "R8", "data held", 32'(data_o), 32'(prev_word));
    end
    @(negedge clk);
    ee_do_i = 1'b0;
    check(busy_o === 1'b0, "R2", "busy drops", 32'(busy_o), 32'(0));
    check(done_o === 1'b1, "R8", "done pulse", 32'(done_o), 32'(1));
    check(data_o === word, "R6", "word value", 32'(data_o), 32'(word));
    @(negedge clk);
    check(done_o === 1'b0, "R8", "done single", 32'(done_o), 32'(0));
    check(data_o === word, "R8", "word kept", 32'(data_o), 32'(word));
    check({ee_cs_o, ee_sk_o, ee_di_o} === 3'b000, "R1", "idle lines",
          32'({ee_cs_o, ee_sk_o, ee_di_o}), 32'(0));
    prev_word = word;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'(1), 32'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy_o, done_o, ee_cs_o, ee_sk_o, ee_di_o} === 5'b0, "R1", "outputs in reset",
          32'({busy_o, done_o, ee_cs_o, ee_sk_o, ee_di_o}), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(data_o === '0, "R1", "data after reset", 32'(data_o), 32'(0));
    check(busy_o === 1'b0, "R1", "idle after reset", 32'(busy_o), 32'(0));
    do_read(6'h00, 16'hA5C3, -5);
    do_read(6'h3F, 16'hFFFF, -5);
    do_read(6'h2A, 16'h0001, -5);
    do_read(6'h15, 16'h8000, 20);    // R9: start while busy must be ignored
    do_read(6'h07, 16'h0000, 100);   // R9: intrusion in the data phase
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule